// File: doc/BRIEF.md
# Tiered Burst Arbiter for a Shared Memory Port

This block decides which of several bus masters may drive a single shared memory-controller port. Masters fall into four fixed tiers. The top tier is a display refresh master. Below it come a CPU system-bus port and then a CPU instruction/data port. The bottom tier is a group of general masters, such as DMA engines. When the port is free, the highest tier with a pending request wins. General masters that request together are served in round-robin order. The tier order is wired into the logic and cannot be changed at run time.

A granted burst owns the port until it ends. It ends when the owner pulses done, or when the owner's stated burst length runs out. A higher-tier request that arrives during a burst waits; there is no preemption. Long low-tier bursts can therefore delay the display master, and shorter bursts reduce that delay. To make this delay visible, the block keeps a saturating register. It holds the longest time the display master has waited between raising its request and receiving the grant.

The grant is a registered one-hot vector. It changes only on a clock edge, at the first edge where the port is free or the current burst has ended.

Top module: `burst_tier_arbiter`

## Requirements
- R1: Master index sets the tier. Bit 0 is the display master, bit 1 the system-bus port, bit 2 the instruction/data port, and bits 3 and up the general masters. When the port is free, the grant goes to the requesting master in the lowest-numbered tier, with the display master first.
- R2: Among general masters, the search starts at a rotating pointer and wraps around. After general master k wins, the pointer moves to the general master just after k. The pointer does not move when a higher tier wins.
- R3: `grant` is registered and is always one-hot or all zero. When the port is free, a request sampled at a clock edge shows up as a grant right after that edge.
- R4: Once a burst has started, the grant stays with its owner, even if a higher-tier master requests. It is kept until the owner's done pulse or the owner's length bound ends the burst.
- R5: A done pulse from a master that does not hold the grant has no effect on the grant.
- R6: The length of master i is taken from `burst_len[i*LEN_W +: LEN_W]` at the edge where master i wins. If that length is nonzero, the grant is held for exactly that many cycles even without done. A length of zero means the burst ends only on done.
- R7: The port is arbitrated again at the edge where the owner's done is sampled, so the next owner takes over with no idle cycle. If nothing is requesting at that edge, `grant` becomes zero and stays zero until a request arrives.
- R8: Each edge where the display master requests and does not hold the grant adds one to a running wait count. Any other edge clears that count. `max_wait` holds the largest running count seen since reset.
- R9: The wait count and `max_wait` saturate at all ones and do not wrap.
- R10: After reset, `grant` is zero, `max_wait` is zero, and the round-robin pointer selects general master 0 (index 3) first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_GEN+3 | Request per master, indexed by tier order |
| done | input | N_GEN+3 | Burst-done pulse per master |
| burst_len | input | (N_GEN+3)*LEN_W | Burst length per master, 0 = unbounded |
| grant | output | N_GEN+3 | One-hot grant, zero when the port is idle |
| max_wait | output | WAIT_W | Longest display-master wait seen since reset |

## Verification
Two situations are hard to reach. The first is saturating `max_wait`. The stimulus does this by handing a general master an unbounded burst and holding it without done for longer than the counter range, while the display master keeps requesting. The second is the round-robin pointer staying put while a higher tier wins. This only shows up when general and CPU requests alternate. A directed sequence interleaves them, and a long random phase with short random lengths and stray done pulses covers the rest. A behavioural model in the bench follows every cycle.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the tiered burst arbiter.
// Assumes master indices 0..2 are the three single-master tiers.
package arb_pkg;
    // Fixed priority tiers, highest first
    typedef enum logic [1:0] {
        TIER_DISPLAY = 2'd0,
        TIER_SYSBUS  = 2'd1,
        TIER_INSTDAT = 2'd2,
        TIER_GENERAL = 2'd3
    } tier_e;

    localparam int FIXED_MASTERS = 3;
    localparam int IDX_DISPLAY   = 0;
    localparam int IDX_SYSBUS    = 1;
    localparam int IDX_INSTDAT   = 2;

    // Width of an index able to address n items, never below one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/arb_rr_pick.sv
`timescale 1ns/1ps
// Module: arb_rr_pick
// Round-robin selector for the general tier. It holds a rotating pointer
// and returns the first requester at or after it, wrapping around.
// Assumes: adv is asserted only in a cycle where the general tier wins.
module arb_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_g,
    input  logic          adv,
    input  logic [PW-1:0] adv_idx,
    output logic          any,
    output logic [PW-1:0] pick_idx
);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic [PW-1:0] ptr;

    // Move the pointer past the master that has just been served
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (adv_idx == LAST) ? '0 : adv_idx + PW'(1);
    end

    // Scan from the farthest offset down, so the nearest requester wins
    always_comb begin
        any      = 1'b0;
        pick_idx = '0;
        for (int off = N - 1; off >= 0; off--) begin
            int k;
            k = (int'(ptr) + off) % N;
            if (req_g[k]) begin
                any      = 1'b1;
                pick_idx = PW'(k);
            end
        end
    end
endmodule

// File: rtl/arb_tier_select.sv
`timescale 1ns/1ps
// Module: arb_tier_select
// Fixed tier priority. It picks the display master, then the system-bus port,
// then the instruction/data port, then the round-robin general winner.
// Assumes: gen_idx is valid whenever gen_any is high.
module arb_tier_select
    import arb_pkg::*;
#(
    parameter int N_MST = 7,
    parameter int IW    = 3,
    parameter int PW    = 2
) (
    input  logic [N_MST-1:0] req,
    input  logic             gen_any,
    input  logic [PW-1:0]    gen_idx,
    output logic             win_any,
    output logic [IW-1:0]    win_idx,
    output tier_e            win_tier
);
    // Priority chain over the three fixed tiers, then the general group
    always_comb begin
        win_any  = 1'b1;
        win_idx  = '0;
        win_tier = TIER_DISPLAY;
        if (req[IDX_DISPLAY]) begin
            win_idx  = IW'(IDX_DISPLAY);
            win_tier = TIER_DISPLAY;
        end else if (req[IDX_SYSBUS]) begin
            win_idx  = IW'(IDX_SYSBUS);
            win_tier = TIER_SYSBUS;
        end else if (req[IDX_INSTDAT]) begin
            win_idx  = IW'(IDX_INSTDAT);
            win_tier = TIER_INSTDAT;
        end else if (gen_any) begin
            win_idx  = IW'(FIXED_MASTERS) + IW'(gen_idx);
            win_tier = TIER_GENERAL;
        end else begin
            win_any  = 1'b0;
        end
    end
endmodule

// File: rtl/arb_burst_ctl.sv
`timescale 1ns/1ps
// Module: arb_burst_ctl
// Burst ownership. It registers the grant and keeps it until the owner's done
// pulse or its latched length bound ends the burst. take marks an arbitration edge.
// Assumes: win_idx is below N_MST when win_any is high.
module arb_burst_ctl #(
    parameter int N_MST = 7,
    parameter int IW    = 3,
    parameter int LEN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_any,
    input  logic [IW-1:0]          win_idx,
    input  logic [N_MST*LEN_W-1:0] burst_len,
    input  logic [N_MST-1:0]       done,
    output logic [N_MST-1:0]       grant,
    output logic                   take
);
    localparam logic [LEN_W-1:0] BEAT_MAX = '1;

    logic [LEN_W-1:0] len_arr [N_MST];
    logic [LEN_W-1:0] beat;
    logic [LEN_W-1:0] limit;
    logic [LEN_W-1:0] len_sel;
    logic             owner_done;
    logic             len_out;

    // Unpack the per-master length fields
    for (genvar i = 0; i < N_MST; i++) begin : g_len
        assign len_arr[i] = burst_len[i*LEN_W +: LEN_W];
    end

    // Burst end: done from the owner only, or the length bound reached
    always_comb begin
        len_sel    = len_arr[win_idx];
        owner_done = |(done & grant);
        len_out    = (limit != '0) && (beat >= limit);
        take       = (grant == '0) || owner_done || len_out;
    end

    // Grant register with beat count and latched length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
            beat  <= '0;
            limit <= '0;
        end else if (take) begin
            grant <= win_any ? (N_MST'(1) << win_idx) : '0;
            beat  <= win_any ? LEN_W'(1) : '0;
            limit <= win_any ? len_sel : '0;
        end else if (beat != BEAT_MAX) begin
            beat  <= beat + LEN_W'(1);
        end
    end
endmodule

// File: rtl/arb_wait_meter.sv
`timescale 1ns/1ps
// Module: arb_wait_meter
// Display wait meter. It counts the edges where the display master requests
// without holding the grant and keeps the saturating peak of that run.
// Assumes: disp_gnt is the registered grant bit of the display master.
module arb_wait_meter #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_req,
    input  logic              disp_gnt,
    output logic [WAIT_W-1:0] max_wait
);
    localparam logic [WAIT_W-1:0] CNT_MAX = '1;

    logic [WAIT_W-1:0] run_cnt;
    logic [WAIT_W-1:0] run_inc;

    // Saturating increment of the running wait
    always_comb run_inc = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + WAIT_W'(1);

    // Track the current wait and keep its peak
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            max_wait <= '0;
        end else if (disp_req && !disp_gnt) begin
            run_cnt <= run_inc;
            if (run_inc > max_wait)
                max_wait <= run_inc;
        end else begin
            run_cnt <= '0;
        end
    end
endmodule

// File: rtl/burst_tier_arbiter.sv
`timescale 1ns/1ps
// Module: burst_tier_arbiter
// Tiered, non-preemptive burst arbiter for one shared memory port, with
// round-robin among the general masters and a display wait meter.
// Assumes: master 0 is the display master, 1 the system-bus port,
// 2 the instruction/data port, and 3 and up the general masters.
module burst_tier_arbiter
    import arb_pkg::*;
#(
    parameter int N_GEN  = 4,
    parameter int LEN_W  = 8,
    parameter int WAIT_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_GEN+FIXED_MASTERS-1:0]       req,
    input  logic [N_GEN+FIXED_MASTERS-1:0]       done,
    input  logic [(N_GEN+FIXED_MASTERS)*LEN_W-1:0] burst_len,
    output logic [N_GEN+FIXED_MASTERS-1:0]       grant,
    output logic [WAIT_W-1:0]                  max_wait
);
    localparam int N_MST = N_GEN + FIXED_MASTERS;
    localparam int IW    = idx_width(N_MST);
    localparam int PW    = idx_width(N_GEN);

    logic          gen_any;
    logic [PW-1:0] gen_idx;
    logic          win_any;
    logic [IW-1:0] win_idx;
    tier_e         win_tier;
    logic          take;
    logic          rr_adv;

    // The pointer moves only when the general tier wins an arbitration edge
    always_comb rr_adv = take && win_any && (win_tier == TIER_GENERAL);

    arb_rr_pick #(.N(N_GEN), .PW(PW)) u_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_g    (req[N_MST-1:FIXED_MASTERS]),
        .adv      (rr_adv),
        .adv_idx  (gen_idx),
        .any      (gen_any),
        .pick_idx (gen_idx)
    );

    arb_tier_select #(.N_MST(N_MST), .IW(IW), .PW(PW)) u_sel (
        .req      (req),
        .gen_any  (gen_any),
        .gen_idx  (gen_idx),
        .win_any  (win_any),
        .win_idx  (win_idx),
        .win_tier (win_tier)
    );

    arb_burst_ctl #(.N_MST(N_MST), .IW(IW), .LEN_W(LEN_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_any   (win_any),
        .win_idx   (win_idx),
        .burst_len (burst_len),
        .done      (done),
        .grant     (grant),
        .take      (take)
    );

    arb_wait_meter #(.WAIT_W(WAIT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .disp_req (req[IDX_DISPLAY]),
        .disp_gnt (grant[IDX_DISPLAY]),
        .max_wait (max_wait)
    );
endmodule

// File: rtl/arb_checker.sv
`timescale 1ns/1ps
// Module: arb_checker
// Property checker for burst_tier_arbiter, bound to every instance.
// It follows burst ownership from the ports alone and checks hold,
// release, priority and meter rules.
module arb_checker #(
    parameter int N_GEN  = 4,
    parameter int LEN_W  = 8,
    parameter int WAIT_W = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [N_GEN+3-1:0]             req,
    input logic [N_GEN+3-1:0]             done,
    input logic [(N_GEN+3)*LEN_W-1:0]     burst_len,
    input logic [N_GEN+3-1:0]             grant,
    input logic [WAIT_W-1:0]              max_wait
);
    localparam int N = N_GEN + 3;

    logic                 new_q;
    logic [N*LEN_W-1:0]   bl_q;
    logic [LEN_W-1:0]     run_c, lim_c, run_eff, lim_eff, own_len;
    logic                 rel_exp;

    // Length of the current owner, as offered at the edge where it won
    always_comb begin
        own_len = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) own_len = bl_q[i*LEN_W +: LEN_W];
        run_eff = new_q ? LEN_W'(1) : run_c;
        lim_eff = new_q ? own_len : lim_c;
        rel_exp = (grant == '0) || (|(grant & done)) ||
                  ((lim_eff != '0) && (run_eff >= lim_eff));
    end

    // Ownership tracker, updated from port values only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= 1'b1;
            bl_q  <= '0;
            run_c <= '0;
            lim_c <= '0;
        end else begin
            new_q <= rel_exp;
            bl_q  <= burst_len;
            run_c <= (run_eff == '1) ? run_eff : run_eff + LEN_W'(1);
            lim_c <= lim_eff;
        end
    end

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3
    AST_DISPLAY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rel_exp && req[0] |=> grant[0]); // R1
    AST_BURST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_exp |=> $stable(grant)); // R4
    AST_LEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) && (lim_eff != '0) && (run_eff >= lim_eff) && !(|req) |=> grant == '0); // R6
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rel_exp && !(|req) |=> grant == '0); // R7
    AST_WAIT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> max_wait >= $past(max_wait)); // R8
endmodule

bind burst_tier_arbiter arb_checker #(
    .N_GEN(N_GEN), .LEN_W(LEN_W), .WAIT_W(WAIT_W)
) u_arb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .done      (done),
    .burst_len (burst_len),
    .grant     (grant),
    .max_wait  (max_wait)
);

// File: tb/burst_tier_arbiter_tb.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model compared with the arbiter on every clock.
module burst_tier_arbiter_tb;
    localparam int NG = 4, LW = 8, WW = 8, NM = NG + 3;
    localparam int WMAX = (1 << WW) - 1, LMAX = (1 << LW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NM-1:0] req = '0, done = '0;
    logic [NM*LW-1:0] blen = '0;
    logic [NM-1:0] grant;
    logic [WW-1:0] max_wait;
    int lens [NM];
    int n_chk = 0, n_fail = 0;
    int m_own = -1, m_beat = 0, m_lim = 0, m_ptr = 0, m_cur = 0, m_max = 0;
    string tag = "R10";

    always #5 clk = ~clk;

    burst_tier_arbiter #(.N_GEN(NG), .LEN_W(LW), .WAIT_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done),
        .burst_len(blen), .grant(grant), .max_wait(max_wait));

    task automatic chk(input string t, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    function automatic int pick(input logic [NM-1:0] r);
        for (int m = 0; m < 3; m++) if (r[m]) return m;
        for (int off = 0; off < NG; off++) if (r[3 + (m_ptr + off) % NG]) return 3 + (m_ptr + off) % NG;
        return -1;
    endfunction

    task automatic step(input logic [NM-1:0] r, input logic [NM-1:0] d);
        bit tk;
        int w;
        logic [NM-1:0] ev;
        @(negedge clk);
        req = r; done = d;
        for (int i = 0; i < NM; i++) blen[i*LW +: LW] = LW'(lens[i]);
        if (r[0] && m_own != 0) begin
            if (m_cur < WMAX) m_cur++;
            if (m_cur > m_max) m_max = m_cur;
        end else m_cur = 0;
        tk = (m_own < 0) || (m_lim != 0 && m_beat >= m_lim);
        if (m_own >= 0 && d[m_own]) tk = 1;
        if (tk) begin
            w = pick(r);
            if (w >= 3) m_ptr = (w - 3 + 1) % NG;
            m_own = w; m_beat = (w >= 0) ? 1 : 0; m_lim = (w >= 0) ? lens[w] : 0;
        end else if (m_beat < LMAX) m_beat++;
        @(posedge clk); #1;
        ev = (m_own < 0) ? '0 : NM'(1) << m_own;
        chk({tag, " grant"}, grant, ev);
        chk({tag, " max_wait"}, max_wait, m_max);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NM; i++) lens[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R10 reset grant", grant, 0);
        chk("R10 reset max_wait", max_wait, 0);

        // R10/R2: pointer starts at general 0; rotation with length 1
        tag = "R2 rotate";
        for (int i = 3; i < NM; i++) lens[i] = 1;
        step(7'b1111000, '0);
        chk("R10 first general is index 3", grant, 7'b0001000);
        for (int i = 0; i < 5; i++) step(7'b1111000, '0);
        // R2: pointer holds while a CPU tier wins
        tag = "R2 pointer hold";
        lens[1] = 1;
        step(7'b0000010, '0);
        step(7'b1111000, '0);
        step(7'b0000000, '0);

        // R1: all request at once, display first, then the lower tiers in order
        tag = "R1 tiers";
        for (int i = 0; i < NM; i++) lens[i] = 1;
        step(7'b1111111, '0);
        chk("R1 display wins", grant, 7'b0000001);
        step(7'b1111110, '0);
        step(7'b1111100, '0);
        step(7'b1111000, '0);
        step(7'b0000000, '0);

        // R4/R5: unbounded burst, display waits, foreign done ignored
        tag = "R4 hold";
        lens[5] = 0;
        step(7'b0100000, '0);
        step(7'b0100001, '0);
        tag = "R5 foreign done";
        step(7'b0100001, 7'b0000011);
        step(7'b0100001, 7'b1000001);
        chk("R5 grant kept", grant, 7'b0100000);
        // R7: owner done, display takes over at once
        tag = "R7 handover";
        lens[0] = 0;
        step(7'b0100001, 7'b0100000);
        chk("R7 display next", grant, 7'b0000001);
        step(7'b0000000, 7'b0000001);
        step(7'b0000000, '0);
        chk("R7 idle grant zero", grant, 0);

        // R6: length 3 held exactly three cycles, then released
        tag = "R6 length";
        lens[4] = 3;
        step(7'b0010000, '0);
        step(7'b0000010, '0);
        step(7'b0000010, '0);
        chk("R6 still held", grant, 7'b0010000);
        step(7'b0000010, '0);
        chk("R6 released", grant, 7'b0000010);
        step(7'b0000000, 7'b0000010);
        step(7'b0000000, '0);

        // R8/R9: display starved by an unbounded burst until saturation
        tag = "R8 wait";
        lens[6] = 0;
        step(7'b1000000, '0);
        for (int i = 0; i < 300; i++) begin
            if (i == 280) tag = "R9 saturate";
            step(7'b1000001, '0);
        end
        chk("R9 saturated", max_wait, WMAX);
        step(7'b0000001, 7'b1000000);
        step(7'b0000000, 7'b0000001);

        // Random mixed traffic with short lengths and stray done pulses
        tag = "R3 random";
        for (int c = 0; c < 3000; c++) begin
            if (c % 16 == 0) for (int i = 0; i < NM; i++) lens[i] = $urandom_range(0, 4);
            step(NM'($urandom) & NM'($urandom), ($urandom_range(0, 3) == 0) ? NM'($urandom) : '0);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule